// File: doc/BRIEF.md
# Power Domain Sleep Sequencer

This block sits in the always-on area of a chip and steps one switchable logic domain between three conditions: running, clock-stopped (light sleep) and unpowered (deep sleep). It drives five control lines toward the domain: a retention-save strobe, a retention-restore strobe, an isolation enable, the domain clock enable and the power-switch enable. Its state and its five controls are the only things it holds; all else about the domain is outside it.

A local agent asks for sleep with a one-cycle request and a mode bit. Wake events come from a timer line or an external interrupt line; either one counts. On a deep wake the sequencer closes the switch and waits for a power-good input, passed through a synchronizer, before the clock restarts. A fixed cycle budget bounds this wait. If the budget runs out first, the sequencer carries on and sets a sticky error flag. A wake during the power-down steps reverses the steps already taken. A sleep request during the power-up steps is held until the domain is running again.

Every step takes one clock cycle. Apart from the power-good wait, the number of cycles from a wake event to a running domain is always the same.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in the running state: `dom_active`=1, `dom_clk_en`=1, `pwr_sw_en`=1, `iso_en`=0, both retention strobes 0 and `settle_err`=0.
- R2: In the running state, `sleep_req`=1 with `sleep_deep`=0 stops the clock from the next cycle, with the switch on and isolation off. A wake event while in light sleep restores the clock and `dom_active` on the next cycle, with no retention strobe.
- R3: In the running state, `sleep_req`=1 with `sleep_deep`=1 gives this order, one cycle per step: `ret_save` high for exactly one cycle, then `iso_en` rises, then `dom_clk_en` falls, then `pwr_sw_en` falls. The domain then stays in deep sleep.
- R4: A wake event in deep sleep (`wake_timer` or `wake_irq` high) turns the switch on in the next cycle. The clock stays off until the two-stage synchronized `pwr_good_in` reads high, or until the settle budget runs out. `dom_clk_en` rises in the cycle after that.
- R5: The switch is off only while isolation is on and the clock is off.
- R6: `ret_restore` is a one-cycle pulse, with clock, switch and isolation all on. It is issued on the cycle after the clock restarts, and only when power was actually removed.
- R7: Isolation drops on the cycle after the restore pulse, or after the clock restart when no restore is due. `dom_active` rises one cycle after isolation drops.
- R8: If the synchronized power-good is still low after `SETTLE_CYCLES` cycles of waiting, the sequencer goes on to the clock restart and sets `settle_err`. The flag stays set until reset.
- R9: A wake event during the power-down steps reverses them from the current step. During the save step, the next state is running. During the isolate step, isolation drops and then running follows. During the clock-stop step, the clock restarts, isolation drops and running follows, with no restore pulse.
- R10: A `sleep_req` during the power-up steps is held with its mode. It is acted on in the first running cycle, so the domain spends exactly one cycle running before the held request starts.
- R11: Wake events in the running state have no effect. A `sleep_req` during the power-down steps or during either sleep state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_deep | input | 1 | Mode with the request: 1 removes power, 0 stops the clock only |
| wake_timer | input | 1 | Wake event from a timer expiry |
| wake_irq | input | 1 | Wake event from an external interrupt |
| pwr_good_in | input | 1 | Asynchronous supply-settled indication from the domain |
| ret_save | output | 1 | Retention save strobe |
| ret_restore | output | 1 | Retention restore strobe |
| iso_en | output | 1 | Isolation enable for the domain outputs |
| dom_clk_en | output | 1 | Domain clock enable |
| pwr_sw_en | output | 1 | Power switch enable (1 = powered) |
| dom_active | output | 1 | Domain is in normal operation |
| settle_err | output | 1 | Sticky flag: supply did not settle in time |

## Verification
The ordering properties rely on only two things about the inputs: the request and wake lines are sampled synchronously, and `pwr_good_in` may change at any time. The stimulus drives requests and wakes on the falling clock edge, as one-cycle pulses or held levels. Power-good comes from a delayed copy of the switch enable, which can be forced low to use up the settle budget. Wake pulses are placed one, two and three cycles after a deep request, so that the save, isolate and clock-stop steps are each interrupted at least once. Requests are issued while the supply is settling, to exercise the held-request path.

// File: rtl/pwr_seq_pkg.sv
// Package: state type and per-state control bundle for the power domain
// sequencer. Assumes one sequencer per switchable domain.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        PS_RUN,
        PS_SAVE,
        PS_ISOLATE,
        PS_CLK_STOP,
        PS_DEEP,
        PS_LIGHT,
        PS_SETTLE,
        PS_CLK_START,
        PS_RESTORE,
        PS_UNISOLATE
    } pseq_state_e;

    typedef struct packed {
        logic save;
        logic restore;
        logic iso;
        logic clk;
        logic sw;
    } pseq_ctrl_t;

    // Maps a state onto the five domain control lines.
    function automatic pseq_ctrl_t ctrl_of(pseq_state_e s);
        pseq_ctrl_t c;
        c = '{save: 1'b0, restore: 1'b0, iso: 1'b0, clk: 1'b1, sw: 1'b1};
        case (s)
            PS_SAVE:      c.save = 1'b1;
            PS_ISOLATE:   c.iso = 1'b1;
            PS_CLK_STOP:  begin c.iso = 1'b1; c.clk = 1'b0; end
            PS_DEEP:      begin c.iso = 1'b1; c.clk = 1'b0; c.sw = 1'b0; end
            PS_LIGHT:     c.clk = 1'b0;
            PS_SETTLE:    begin c.iso = 1'b1; c.clk = 1'b0; end
            PS_CLK_START: c.iso = 1'b1;
            PS_RESTORE:   begin c.iso = 1'b1; c.restore = 1'b1; end
            default:      c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// Assumes the input is a slow level; the output is low after reset.
module pwr_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_settle_timer.sv
// Counts cycles spent waiting for the supply. Cleared whenever run is low.
// expired is high in the LIMIT-th consecutive run cycle. Assumes LIMIT >= 2.
module pwr_seq_settle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count while waiting, restart at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run)               cnt <= '0;
        else if (cnt != LAST)        cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/pwr_seq_fsm.sv
// Sequencing state machine: ordered power-down and mirrored power-up,
// abort of power-down on wake, holding of requests made during power-up.
// Assumes sleep_req and wake are synchronous to clk.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_req,
    input  logic        sleep_deep,
    input  logic        wake,
    input  logic        pg_ok,
    input  logic        tmo,
    output pseq_state_e state,
    output logic        settle_err
);
    pseq_state_e nxt;
    logic        held, held_deep, pwr_lost;
    logic        go, go_deep, waking;

    assign waking  = (state == PS_SETTLE) || (state == PS_CLK_START) ||
                     (state == PS_RESTORE) || (state == PS_UNISOLATE);
    assign go      = sleep_req || held;
    assign go_deep = sleep_req ? sleep_deep : held_deep;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            PS_RUN:       if (go) nxt = go_deep ? PS_SAVE : PS_LIGHT;
            PS_SAVE:      nxt = wake ? PS_RUN : PS_ISOLATE;
            PS_ISOLATE:   nxt = wake ? PS_UNISOLATE : PS_CLK_STOP;
            PS_CLK_STOP:  nxt = wake ? PS_CLK_START : PS_DEEP;
            PS_DEEP:      if (wake) nxt = PS_SETTLE;
            PS_LIGHT:     if (wake) nxt = PS_RUN;
            PS_SETTLE:    if (pg_ok || tmo) nxt = PS_CLK_START;
            PS_CLK_START: nxt = pwr_lost ? PS_RESTORE : PS_UNISOLATE;
            PS_RESTORE:   nxt = PS_UNISOLATE;
            PS_UNISOLATE: nxt = PS_RUN;
            default:      nxt = PS_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt;
    end

    // Hold a request made while powering up; drop it once running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_deep <= 1'b0;
        end else if (state == PS_RUN) begin
            held      <= 1'b0;
        end else if (waking && sleep_req) begin
            held      <= 1'b1;
            held_deep <= sleep_deep;
        end
    end

    // Remember whether the supply was actually removed in this cycle of sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pwr_lost <= 1'b0;
        else if (state == PS_DEEP)   pwr_lost <= 1'b1;
        else if (state == PS_RUN)    pwr_lost <= 1'b0;
    end

    // Sticky flag for a supply that never reported good.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    settle_err <= 1'b0;
        else if (state == PS_SETTLE && tmo && !pg_ok)  settle_err <= 1'b1;
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the power domain sequencer. Synchronizes power-good, times the
// supply wait and decodes the sequencer state into the domain controls.
// Assumes clk is always on and rst_n is synchronous, active low.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sleep_deep,
    input  logic wake_timer,
    input  logic wake_irq,
    input  logic pwr_good_in,
    output logic ret_save,
    output logic ret_restore,
    output logic iso_en,
    output logic dom_clk_en,
    output logic pwr_sw_en,
    output logic dom_active,
    output logic settle_err
);
    pseq_state_e st;
    pseq_ctrl_t  ctl;
    logic        pg_sync, tmo;

    pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pwr_good_in), .q_sync(pg_sync)
    );

    pwr_seq_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st == PS_SETTLE), .expired(tmo)
    );

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .wake(wake_timer || wake_irq),
        .pg_ok(pg_sync), .tmo(tmo),
        .state(st), .settle_err(settle_err)
    );

    assign ctl         = ctrl_of(st);
    assign ret_save    = ctl.save;
    assign ret_restore = ctl.restore;
    assign iso_en      = ctl.iso;
    assign dom_clk_en  = ctl.clk;
    assign pwr_sw_en   = ctl.sw;
    assign dom_active  = (st == PS_RUN);
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
// Ordering checks on the domain control lines, bound to pwr_seq_ctrl.
module pwr_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ret_save,
    input logic ret_restore,
    input logic iso_en,
    input logic dom_clk_en,
    input logic pwr_sw_en,
    input logic settle_err
);
    AST_SW_OFF_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_sw_en |-> (iso_en && !dom_clk_en));                          // R5
    AST_SW_FALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_sw_en) |-> $past(iso_en && !dom_clk_en));               // R3
    AST_ISO_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en) |-> $past(ret_save));                               // R3
    AST_CLK_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dom_clk_en) && iso_en) |-> (pwr_sw_en && $past(pwr_sw_en))); // R4
    AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore |=> !ret_restore);                                    // R6
    AST_RESTORE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore |-> (dom_clk_en && pwr_sw_en && iso_en));             // R6
    AST_ISO_DROP_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (dom_clk_en && pwr_sw_en && !ret_restore));     // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        settle_err |=> settle_err);                                       // R8
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_save, ret_restore}));                               // R3
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ret_save(ret_save), .ret_restore(ret_restore),
    .iso_en(iso_en), .dom_clk_en(dom_clk_en), .pwr_sw_en(pwr_sw_en),
    .settle_err(settle_err)
);

// File: tb/pwr_seq_ctrl_bench.sv
// Bench: behavioural reference of the sequencer, compared every cycle.
module pwr_seq_ctrl_bench;
    localparam int SETTLE = 8;
    localparam int PG_DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, sleep_deep = 1'b0;
    logic wake_timer = 1'b0, wake_irq = 1'b0;
    logic pwr_good_in = 1'b0, pg_block = 1'b0;
    logic ret_save, ret_restore, iso_en, dom_clk_en, pwr_sw_en, dom_active, settle_err;
    logic [7:0] sw_hist = 8'hFF;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string scen = "R1 reset";

    always #4 clk = ~clk;   // 125 MHz

    pwr_seq_ctrl #(.SETTLE_CYCLES(SETTLE)) u_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .wake_timer(wake_timer), .wake_irq(wake_irq), .pwr_good_in(pwr_good_in),
        .ret_save(ret_save), .ret_restore(ret_restore), .iso_en(iso_en),
        .dom_clk_en(dom_clk_en), .pwr_sw_en(pwr_sw_en), .dom_active(dom_active),
        .settle_err(settle_err)
    );

    // Supply model: power-good follows the switch after PG_DLY cycles.
    always @(negedge clk) begin
        sw_hist = {sw_hist[6:0], pwr_sw_en};
        pwr_good_in = sw_hist[PG_DLY-1] && !pg_block;
    end

    // Reference model phases.
    localparam int M_RUN = 0, M_SAVE = 1, M_ISO = 2, M_CSTOP = 3, M_DEEP = 4,
                   M_LIGHT = 5, M_WAIT = 6, M_CSTART = 7, M_REST = 8, M_UNISO = 9;
    int ph = M_RUN, wait_n = 0, pg1 = 0, pg2 = 0;
    bit m_err = 0, m_hold = 0, m_hold_deep = 0, m_lost = 0;

    always @(posedge clk) begin
        int nx;
        bit wk, pgv, up;
        if (!rst_n) begin
            ph = M_RUN; wait_n = 0; pg1 = 0; pg2 = 0;
            m_err = 0; m_hold = 0; m_hold_deep = 0; m_lost = 0;
        end else begin
            wk  = wake_timer || wake_irq;
            pgv = (pg2 != 0);
            up  = (ph == M_WAIT) || (ph == M_CSTART) || (ph == M_REST) || (ph == M_UNISO);
            nx  = ph;
            if (ph == M_RUN) begin
                if (sleep_req)   nx = sleep_deep ? M_SAVE : M_LIGHT;
                else if (m_hold) nx = m_hold_deep ? M_SAVE : M_LIGHT;
            end else if (ph == M_SAVE)  nx = wk ? M_RUN : M_ISO;
            else if (ph == M_ISO)       nx = wk ? M_UNISO : M_CSTOP;
            else if (ph == M_CSTOP)     nx = wk ? M_CSTART : M_DEEP;
            else if (ph == M_DEEP)      nx = wk ? M_WAIT : M_DEEP;
            else if (ph == M_LIGHT)     nx = wk ? M_RUN : M_LIGHT;
            else if (ph == M_WAIT) begin
                if (pgv || wait_n == SETTLE - 1) nx = M_CSTART;
                if (!pgv && wait_n == SETTLE - 1) m_err = 1;
            end
            else if (ph == M_CSTART)    nx = m_lost ? M_REST : M_UNISO;
            else if (ph == M_REST)      nx = M_UNISO;
            else if (ph == M_UNISO)     nx = M_RUN;
            if (ph == M_RUN) m_hold = 0;
            else if (up && sleep_req) begin m_hold = 1; m_hold_deep = sleep_deep; end
            if (ph == M_DEEP) m_lost = 1;
            else if (ph == M_RUN) m_lost = 0;
            wait_n = (ph == M_WAIT) ? wait_n + 1 : 0;
            pg2 = pg1; pg1 = pwr_good_in;
            ph = nx;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%b expected=%b", tag, scen, $time, act, exp);
        end
    endtask

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 ret_save",    ret_save,    ph == M_SAVE);
            chk("R6 ret_restore", ret_restore, ph == M_REST);
            chk("R7 iso_en",      iso_en,      ph inside {M_ISO, M_CSTOP, M_DEEP, M_WAIT, M_CSTART, M_REST});
            chk("R4 dom_clk_en",  dom_clk_en,  !(ph inside {M_CSTOP, M_DEEP, M_LIGHT, M_WAIT}));
            chk("R5 pwr_sw_en",   pwr_sw_en,   ph != M_DEEP);
            chk("R2 dom_active",  dom_active,  ph == M_RUN);
            chk("R8 settle_err",  settle_err,  m_err);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input logic deep);
        @(negedge clk); sleep_req = 1'b1; sleep_deep = deep;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic wake_pulse(input logic use_irq);
        if (use_irq) wake_irq = 1'b1; else wake_timer = 1'b1;
        @(negedge clk); wake_irq = 1'b0; wake_timer = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        idle(3); rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset active", dom_active, 1'b1);
        chk("R1 reset clk",    dom_clk_en, 1'b1);
        chk("R1 reset sw",     pwr_sw_en,  1'b1);
        chk("R1 reset iso",    iso_en,     1'b0);
        chk("R1 reset err",    settle_err, 1'b0);
        chk("R1 reset strobes", ret_save | ret_restore, 1'b0);
    endtask

    initial begin
        idle(3);
        do_reset();
        scen = "R11 wake in run"; idle(2); wake_pulse(1); idle(2);
        chk("R11 still active", dom_active, 1'b1);
        scen = "R2 light sleep"; req(1'b0); idle(4); wake_pulse(0); idle(3);
        scen = "R3 deep entry"; req(1'b1); idle(8);
        scen = "R11 req in deep"; req(1'b0); idle(3);
        chk("R11 switch stays off", pwr_sw_en, 1'b0);
        scen = "R4 deep wake irq"; wake_pulse(1); idle(12);
        chk("R7 back to run", dom_active, 1'b1);
        scen = "R9 abort at save"; req(1'b1); wake_pulse(0); idle(4);
        scen = "R9 abort at isolate"; req(1'b1); idle(1); wake_pulse(1); idle(5);
        scen = "R9 abort at clock stop"; req(1'b1); idle(2); wake_pulse(0); idle(6);
        scen = "R10 held request"; req(1'b1); idle(8); wake_pulse(1); idle(1);
        req(1'b0); idle(12);
        chk("R10 light after held", dom_clk_en, 1'b0);
        wake_pulse(0); idle(3);
        scen = "R8 settle timeout"; req(1'b1); idle(8); pg_block = 1'b1;
        wake_pulse(1); idle(SETTLE + 8);
        chk("R8 err set", settle_err, 1'b1);
        pg_block = 1'b0; idle(4);
        scen = "R1 reset clears err"; do_reset(); idle(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule